// File: doc/BRIEF.md
# UART Hardware Handshake Controller

This block automates the request-to-send / clear-to-send handshake of a UART. It watches the fill level of the receive FIFO against a programmable trigger threshold and drives the active-low request-to-send line. When the FIFO fills to the threshold, the far end is told to stop. When reads drain the FIFO back below the threshold, the far end is released. On the transmit side, it passes the active-low clear-to-send input through a synchronizer. It only lets the serializer start a new character when the far end is ready. A character already being shifted out is never interrupted.

Three configuration bits select the behaviour: a FIFO-mode enable, an automatic-handshake enable and a software request-to-send bit. With FIFOs and automatic handshake both on, the request-to-send bit picks between full mode (both lines automated) and a CTS-only mode (only transmit gating is automated). In every other case the request-to-send pin is simply the inverse of the software bit, and clear-to-send is ignored. A sticky overflow flag records any write into an already full receive FIFO. The FIFOs, the serializer and deserializer, and the baud generator sit outside the block and are seen only through ports.

Top module: `uart_flowctl`

## Requirements
- R1: The mode is full when `cfg_fifo_en`, `cfg_auto_en` and `cfg_rts` are all 1. It is CTS-only when `cfg_fifo_en` and `cfg_auto_en` are 1 and `cfg_rts` is 0. In all other cases it is off.
- R2: In full mode, `rts_n` is 0 one clock edge after the inputs show `rx_level` below the effective threshold.
- R3: In full mode, `rts_n` is 1 one clock edge after `rx_level` reaches or exceeds the effective threshold. It stays 1 until the level is again below the threshold.
- R4: In full or CTS-only mode, `cts_n` passes through two flops before use. No `tx_start` is issued while the synchronized value is 1. After `cts_n` falls with `tx_ready` high and `tx_busy` low, the earliest `tx_start` is seen after the third clock edge.
- R5: `tx_start` is issued only in a cycle following one where `tx_busy` was 0. A rise of `cts_n` while `tx_busy` is 1 neither produces an output change nor stops the character in flight. After the character ends, the next start waits for `cts_n` low.
- R6: In off mode, `cts_n` is ignored. `tx_start` goes to 1 one clock edge after `tx_ready` is 1 with `tx_busy` 0.
- R7: `tx_start` is a one-cycle pulse and is never 1 on two consecutive cycles.
- R8: Outside full mode, `rts_n` equals the inverse of `cfg_rts`, registered on one clock edge.
- R9: The effective threshold is `rx_trig` clamped to the range 1 to DEPTH-1. A value of 0 acts as 1, and values above DEPTH-1 act as DEPTH-1. This leaves one free entry for the character that may still arrive after `rts_n` rises.
- R10: `rx_ovf` is set on the edge after `rx_wr` is 1 while `rx_level` equals DEPTH, whatever the state of `rts_n`. `ovf_clr` clears it, and a simultaneous set wins over the clear.
- R11: Synchronous active-high reset sets `rts_n` to 1, `tx_start` to 0 and `rx_ovf` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_fifo_en | input | 1 | FIFO mode enable |
| cfg_auto_en | input | 1 | Automatic handshake enable |
| cfg_rts | input | 1 | Software request-to-send bit / full-mode select |
| rx_level | input | LVL_W | Receive FIFO entry count, 0..DEPTH |
| rx_trig | input | LVL_W | Programmable receive trigger threshold |
| rx_wr | input | 1 | Deserializer writes a character into the receive FIFO |
| ovf_clr | input | 1 | Clears the overflow flag |
| cts_n | input | 1 | Asynchronous active-low clear-to-send from the far end |
| tx_ready | input | 1 | Transmit FIFO holds a character |
| tx_busy | input | 1 | Serializer is shifting a character |
| rts_n | output | 1 | Active-low request-to-send to the far end |
| tx_start | output | 1 | One-cycle pulse telling the serializer to begin a character |
| rx_ovf | output | 1 | Sticky receive overflow flag |

## Verification
A wrong threshold compare or a wrong mode decode shows up on `rts_n` at the very next clock edge. A slip of one in the clamp shows up only at the levels next to the threshold or next to DEPTH-1, so those levels are driven explicitly. A synchronizer of the wrong depth, or a gate that ignores `tx_busy`, moves or duplicates the `tx_start` pulse. This is observed edge by edge in the three cycles after `cts_n` falls and while the serializer is busy. A broken overflow latch shows up on `rx_ovf` one edge after a write into a full FIFO, or after a clear.

// File: rtl/uflow_pkg.sv
package uflow_pkg;

    typedef enum logic [1:0] {
        FLOW_OFF  = 2'd0,
        FLOW_CTS  = 2'd1,
        FLOW_FULL = 2'd2
    } flow_mode_e;

    typedef struct packed {
        logic fifo_en;
        logic auto_en;
        logic rts_bit;
    } flow_cfg_t;

    // Mode decode (R1)
    function automatic flow_mode_e decode_mode(input flow_cfg_t c);
        if (c.fifo_en && c.auto_en)
            return c.rts_bit ? FLOW_FULL : FLOW_CTS;
        return FLOW_OFF;
    endfunction

    // Threshold clamp into 1..depth-1 (R9)
    function automatic int unsigned clamp_trig(input int unsigned t, input int unsigned depth);
        if (t == 0)
            return 1;
        if (t > depth - 1)
            return depth - 1;
        return t;
    endfunction

endpackage

// File: rtl/uflow_rts_ctl.sv
module uflow_rts_ctl
    import uflow_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  flow_mode_e       mode,
    input  logic             rts_bit,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] trig,
    output logic             rts_n
);
    logic [LVL_W-1:0] lim;
    logic             above;
    logic             rts_n_d;

    always_comb begin
        lim   = LVL_W'(clamp_trig(32'(trig), DEPTH));
        above = (level >= lim);
        if (mode == FLOW_FULL)
            rts_n_d = above;      // R2 / R3
        else
            rts_n_d = ~rts_bit;   // R8
    end

    always_ff @(posedge clk) begin
        if (rst)
            rts_n <= 1'b1;
        else
            rts_n <= rts_n_d;
    end
endmodule

// File: rtl/uflow_cts_gate.sv
module uflow_cts_gate
    import uflow_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  flow_mode_e mode,
    input  logic       cts_n,
    input  logic       tx_ready,
    input  logic       tx_busy,
    output logic       tx_start
);
    logic [STAGES-1:0] sync_q;
    logic              cts_blocked;
    logic              start_d;

    // Synchronizer, resets to "not clear"
    always_ff @(posedge clk) begin
        if (rst)
            sync_q <= '1;
        else
            sync_q <= {sync_q[STAGES-2:0], cts_n};
    end

    always_comb begin
        cts_blocked = (mode != FLOW_OFF) && sync_q[STAGES-1];
        start_d     = tx_ready && !tx_busy && !tx_start && !cts_blocked;
    end

    always_ff @(posedge clk) begin
        if (rst)
            tx_start <= 1'b0;
        else
            tx_start <= start_d;
    end
endmodule

// File: rtl/uflow_ovf_mon.sv
module uflow_ovf_mon #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_wr,
    input  logic [LVL_W-1:0] level,
    input  logic             clr,
    output logic             ovf
);
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

    logic hit;

    always_comb hit = rx_wr && (level == FULL_LVL);

    always_ff @(posedge clk) begin
        if (rst)
            ovf <= 1'b0;
        else if (hit)
            ovf <= 1'b1;
        else if (clr)
            ovf <= 1'b0;
    end
endmodule

// File: rtl/uart_flowctl.sv
module uart_flowctl
    import uflow_pkg::*;
#(
    parameter int unsigned DEPTH       = 16,
    parameter int unsigned LVL_W       = $clog2(DEPTH + 1),
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_fifo_en,
    input  logic             cfg_auto_en,
    input  logic             cfg_rts,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] rx_trig,
    input  logic             rx_wr,
    input  logic             ovf_clr,
    input  logic             cts_n,
    input  logic             tx_ready,
    input  logic             tx_busy,
    output logic             rts_n,
    output logic             tx_start,
    output logic             rx_ovf
);
    flow_cfg_t  cfg;
    flow_mode_e mode;

    always_comb begin
        cfg.fifo_en = cfg_fifo_en;
        cfg.auto_en = cfg_auto_en;
        cfg.rts_bit = cfg_rts;
        mode        = decode_mode(cfg);
    end

    uflow_rts_ctl #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_rts (
        .clk(clk), .rst(rst), .mode(mode), .rts_bit(cfg_rts),
        .level(rx_level), .trig(rx_trig), .rts_n(rts_n)
    );

    uflow_cts_gate #(.STAGES(SYNC_STAGES)) u_cts (
        .clk(clk), .rst(rst), .mode(mode), .cts_n(cts_n),
        .tx_ready(tx_ready), .tx_busy(tx_busy), .tx_start(tx_start)
    );

    uflow_ovf_mon #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_ovf (
        .clk(clk), .rst(rst), .rx_wr(rx_wr), .level(rx_level),
        .clr(ovf_clr), .ovf(rx_ovf)
    );
endmodule

// File: rtl/uart_flowctl_chk.sv
module uart_flowctl_chk
    import uflow_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned LVL_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_fifo_en,
    input logic             cfg_auto_en,
    input logic             cfg_rts,
    input logic [LVL_W-1:0] rx_level,
    input logic [LVL_W-1:0] rx_trig,
    input logic             rx_wr,
    input logic             ovf_clr,
    input logic             tx_busy,
    input logic             rts_n,
    input logic             tx_start,
    input logic             rx_ovf
);
    logic full_mode;
    logic at_limit;
    logic wr_full;

    always_comb begin
        full_mode = cfg_fifo_en && cfg_auto_en && cfg_rts;
        at_limit  = 32'(rx_level) >= clamp_trig(32'(rx_trig), DEPTH);
        wr_full   = rx_wr && (32'(rx_level) == DEPTH);
    end

    p_rts_low_r2: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(full_mode) && !$past(at_limit)) |-> !rts_n);

    p_rts_high_r3: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(full_mode) && $past(at_limit)) |-> rts_n);

    p_start_idle_r5: assert property (@(posedge clk) disable iff (rst)
        tx_start |-> !$past(tx_busy));

    p_single_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        tx_start |=> !tx_start);

    p_rts_manual_r8: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && !$past(full_mode)) |-> (rts_n == !$past(cfg_rts)));

    p_ovf_set_r10: assert property (@(posedge clk) disable iff (rst)
        wr_full |=> rx_ovf);

    p_ovf_clr_r10: assert property (@(posedge clk) disable iff (rst)
        (ovf_clr && !wr_full) |=> !rx_ovf);
endmodule

bind uart_flowctl uart_flowctl_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
    .clk(clk), .rst(rst), .cfg_fifo_en(cfg_fifo_en), .cfg_auto_en(cfg_auto_en),
    .cfg_rts(cfg_rts), .rx_level(rx_level), .rx_trig(rx_trig), .rx_wr(rx_wr),
    .ovf_clr(ovf_clr), .tx_busy(tx_busy), .rts_n(rts_n), .tx_start(tx_start),
    .rx_ovf(rx_ovf)
);

// File: tb/uart_flowctl_tb.sv
module uart_flowctl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int LVL_W      = 5;
    localparam int NVEC       = 14;

    // {fifo_en, auto_en, rts, level[4:0], trig[4:0], expected rts_n}
    localparam logic [13:0] VEC [NVEC] = '{
        {1'b1, 1'b1, 1'b1, 5'd0,  5'd8,  1'b0},  // R2 full, empty
        {1'b1, 1'b1, 1'b1, 5'd7,  5'd8,  1'b0},  // R2 one below
        {1'b1, 1'b1, 1'b1, 5'd8,  5'd8,  1'b1},  // R3 at threshold
        {1'b1, 1'b1, 1'b1, 5'd9,  5'd8,  1'b1},  // R3 above
        {1'b1, 1'b1, 1'b1, 5'd7,  5'd8,  1'b0},  // R3 back below
        {1'b1, 1'b1, 1'b0, 5'd12, 5'd8,  1'b1},  // R1/R8 CTS-only
        {1'b1, 1'b1, 1'b0, 5'd0,  5'd8,  1'b1},  // R1/R8 CTS-only, empty
        {1'b0, 1'b1, 1'b1, 5'd12, 5'd8,  1'b0},  // R1/R8 FIFOs off
        {1'b1, 1'b0, 1'b1, 5'd15, 5'd8,  1'b0},  // R1/R8 auto off
        {1'b1, 1'b0, 1'b0, 5'd0,  5'd8,  1'b1},  // R8 auto off, bit 0
        {1'b1, 1'b1, 1'b1, 5'd14, 5'd16, 1'b0},  // R9 clamp to 15
        {1'b1, 1'b1, 1'b1, 5'd15, 5'd16, 1'b1},  // R9 clamp to 15
        {1'b1, 1'b1, 1'b1, 5'd0,  5'd0,  1'b0},  // R9 zero acts as 1
        {1'b1, 1'b1, 1'b1, 5'd1,  5'd0,  1'b1}   // R9 zero acts as 1
    };

    logic             clk = 1'b0;
    logic             rst;
    logic             cfg_fifo_en, cfg_auto_en, cfg_rts;
    logic [LVL_W-1:0] rx_level, rx_trig;
    logic             rx_wr, ovf_clr, cts_n, tx_ready, tx_busy;
    logic             rts_n, tx_start, rx_ovf;

    int n_total = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    uart_flowctl #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .cfg_fifo_en(cfg_fifo_en), .cfg_auto_en(cfg_auto_en),
        .cfg_rts(cfg_rts), .rx_level(rx_level), .rx_trig(rx_trig), .rx_wr(rx_wr),
        .ovf_clr(ovf_clr), .cts_n(cts_n), .tx_ready(tx_ready), .tx_busy(tx_busy),
        .rts_n(rts_n), .tx_start(tx_start), .rx_ovf(rx_ovf)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_total++;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        rst = 1'b1;
        cfg_fifo_en = 1'b0; cfg_auto_en = 1'b0; cfg_rts = 1'b0;
        rx_level = '0; rx_trig = 5'd8;
        rx_wr = 1'b0; ovf_clr = 1'b0; cts_n = 1'b1; tx_ready = 1'b0; tx_busy = 1'b0;
        repeat (3) step();
        chk("R11 rts_n in reset", rts_n, 1'b1);
        chk("R11 tx_start in reset", tx_start, 1'b0);
        chk("R11 rx_ovf in reset", rx_ovf, 1'b0);
        @(negedge clk) rst = 1'b0;

        // Table walk: R1, R2, R3, R8, R9
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            cfg_fifo_en = VEC[i][13];
            cfg_auto_en = VEC[i][12];
            cfg_rts     = VEC[i][11];
            rx_level    = VEC[i][10:6];
            rx_trig     = VEC[i][5:1];
            step();
            chk($sformatf("R1/R2/R3/R8/R9 vector %0d rts_n", i), rts_n, VEC[i][0]);
        end

        // R4: blocked while cts_n high, then three-edge latency
        @(negedge clk);
        cfg_fifo_en = 1'b1; cfg_auto_en = 1'b1; cfg_rts = 1'b1;
        rx_level = '0; rx_trig = 5'd8; cts_n = 1'b1; tx_ready = 1'b1; tx_busy = 1'b0;
        for (int i = 0; i < 5; i++) begin
            step();
            chk("R4 blocked by cts_n high", tx_start, 1'b0);
        end
        @(negedge clk) cts_n = 1'b0;
        step(); chk("R4 edge 1 no start", tx_start, 1'b0);
        step(); chk("R4 edge 2 no start", tx_start, 1'b0);
        step(); chk("R4 edge 3 start", tx_start, 1'b1);

        // R5: cts_n rises while character in flight
        @(negedge clk) begin tx_busy = 1'b1; cts_n = 1'b1; end
        for (int i = 0; i < 4; i++) begin
            step();
            chk("R5 no start while busy", tx_start, 1'b0);
        end
        @(negedge clk) tx_busy = 1'b0;
        for (int i = 0; i < 3; i++) begin
            step();
            chk("R4 next start waits for cts_n", tx_start, 1'b0);
        end
        @(negedge clk) begin cts_n = 1'b0; tx_busy = 1'b1; end
        for (int i = 0; i < 4; i++) begin
            step();
            chk("R5 busy holds start with cts_n low", tx_start, 1'b0);
        end
        @(negedge clk) tx_busy = 1'b0;
        step(); chk("R5 start after busy drops", tx_start, 1'b1);
        step(); chk("R7 pulse ends after one cycle", tx_start, 1'b0);
        @(negedge clk) tx_ready = 1'b0;

        // R6: off mode ignores cts_n
        @(negedge clk) begin cfg_fifo_en = 1'b0; cts_n = 1'b1; tx_ready = 1'b1; end
        step(); chk("R6 off mode start despite cts_n high", tx_start, 1'b1);
        step(); chk("R7 no back-to-back start", tx_start, 1'b0);
        @(negedge clk) tx_ready = 1'b0;

        // R10: overflow flag
        @(negedge clk) begin
            cfg_fifo_en = 1'b1; cfg_auto_en = 1'b1; cfg_rts = 1'b1;
            rx_level = 5'd15; rx_wr = 1'b1;
        end
        step(); chk("R10 write at 15 no overflow", rx_ovf, 1'b0);
        @(negedge clk) rx_level = 5'd16;
        step(); chk("R10 write when full sets flag", rx_ovf, 1'b1);
        chk("R10 rts_n high while full", rts_n, 1'b1);
        @(negedge clk) begin rx_wr = 1'b0; ovf_clr = 1'b1; end
        step(); chk("R10 clear", rx_ovf, 1'b0);
        @(negedge clk) rx_wr = 1'b1;
        step(); chk("R10 set wins over clear", rx_ovf, 1'b1);
        @(negedge clk) rx_wr = 1'b0;
        step(); chk("R10 clear after set", rx_ovf, 1'b0);
        @(negedge clk) ovf_clr = 1'b0;

        // R11: reset mid-run
        @(negedge clk) begin rx_level = 5'd2; rx_wr = 1'b1; rx_level = 5'd16; end
        step();
        @(negedge clk) begin rst = 1'b1; rx_wr = 1'b0; rx_level = '0; tx_ready = 1'b1; end
        step();
        chk("R11 rts_n after mid-run reset", rts_n, 1'b1);
        chk("R11 rx_ovf after mid-run reset", rx_ovf, 1'b0);
        chk("R11 tx_start after mid-run reset", tx_start, 1'b0);

        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule